// File: doc/BRIEF.md
# Dual-Rail Word Receiver with Completion Detection

This block accepts an N-bit word whose every bit travels on a pair of wires, a "true" rail and a "false" rail. A pair with exactly one rail high carries a valid bit, and a pair with both rails low is the spacer. There is no separate request line. The arrival of a complete valid word is the request, and the receiver answers it with an acknowledge. The transfer follows a four-phase, return-to-zero cycle. The sender drives a valid word and the receiver raises acknowledge. The sender then returns every pair to the spacer and the receiver lowers acknowledge.

Inside the clock domain, the rails first pass through a multi-flop synchroniser. Each bit's validity is the OR of its two rails. A clocked C-element merges all validity bits into one completion signal. That signal rises only when every bit is valid, falls only when every bit is spacer, and keeps its value in any mixed state. On the rising edge of completion, the decoded word is captured and held for the whole acknowledge phase. A pair with both rails high is illegal and sets a sticky error flag.

Top module: `dr_word_receiver`

## Requirements
- R1: A pair with the true rail high and the false rail low decodes to 1. A pair with the false rail high and the true rail low decodes to 0. A pair with both rails low is the spacer. Bit i of `word_o` comes from pair i (`rail_t_i[i]`, `rail_f_i[i]`).
- R2: `done_o` rises only once every pair is valid, where a pair is valid if either of its rails is high. While only some pairs are valid, `done_o` and `ack_o` stay low.
- R3: `done_o` falls only once every pair is back to the spacer. While only some pairs have returned to the spacer, `done_o` and `ack_o` stay high.
- R4: Rails that change at the inputs reach `done_o` after 3 rising clock edges (two synchroniser flops and the C-element), and reach `ack_o` after 4 edges. `ack_o` follows `done_o` one clock later, on both rise and fall.
- R5: `word_o` is loaded with the decoded word when `done_o` rises. It holds that value while `ack_o` is high, even if the rails change.
- R6: A pair with both rails high sets `err_o`. `err_o` stays set through later transfers until reset.
- R7: While `rst_n` is low at a clock edge, `ack_o`, `done_o`, `err_o` and `word_o` go to 0.
- R8: Back-to-back four-phase transfers each deliver their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_t_i | input | WIDTH | True rail of each bit pair |
| rail_f_i | input | WIDTH | False rail of each bit pair |
| done_o | output | 1 | Merged completion (C-element state) |
| ack_o | output | 1 | Four-phase acknowledge |
| word_o | output | WIDTH | Captured decoded word |
| err_o | output | 1 | Sticky illegal-code flag |

## Verification
The bench builds the block at its default width of 8 with a two-stage synchroniser. At that width, the all-zero and all-one words and single-bit corner words each go through a full handshake, and each bit position is exercised as both a 0 and a 1. The 3-edge and 4-edge latencies are sampled edge by edge, so a missing or extra register is detected. Half-valid and half-returned words show that the C-element holds its state. An illegal pair on one bit shows that the error flag stays set through a later transfer and clears only on reset.

// File: rtl/dr_pkg.sv
// Shared definitions for the dual-rail receiver.
// Assumes: rails are encoded as {true, false}, and the spacer is 2'b00.
package dr_pkg;
    typedef enum logic [1:0] {
        PAIR_SPACER  = 2'b00,
        PAIR_ZERO    = 2'b01,
        PAIR_ONE     = 2'b10,
        PAIR_ILLEGAL = 2'b11
    } pair_code_e;
endpackage

// File: rtl/dr_sync.sv
// Multi-flop synchroniser for a bus of rail bits.
// Assumes: rails may change at any time relative to clk. Metastability is not modelled.
module dr_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the rail bus one flop deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dr_pair_decode.sv
// Decodes one synchronised rail pair into value, validity and illegal flag.
// Assumes: inputs are already in the clock domain.
module dr_pair_decode
    import dr_pkg::*;
(
    input  logic rail_t,
    input  logic rail_f,
    output logic value_o,
    output logic valid_o,
    output logic illegal_o
);
    pair_code_e code;

    // Classify the pair and derive its three outputs.
    always_comb begin
        code      = pair_code_e'({rail_t, rail_f});
        value_o   = (code == PAIR_ONE);
        valid_o   = (code != PAIR_SPACER);
        illegal_o = (code == PAIR_ILLEGAL);
    end
endmodule

// File: rtl/dr_celem.sv
// Clocked model of an N-input C-element: set when all inputs are 1,
// clear when all are 0, hold otherwise.
// Assumes: inputs are synchronous to clk.
module dr_celem #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_i,
    output logic             state_o
);
    logic all_high, all_low;

    // Detect agreement among all inputs.
    always_comb begin
        all_high = &in_i;
        all_low  = ~|in_i;
    end

    // Update the held state only when the inputs agree.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_o <= 1'b0;
        else if (all_high) state_o <= 1'b1;
        else if (all_low)  state_o <= 1'b0;
    end

    // R2: a rise needs all inputs valid in the previous cycle.
    a_r2_rise_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_o && !(&in_i)) |=> !state_o);
    // R3: a fall needs all inputs at spacer in the previous cycle.
    a_r3_fall_needs_none: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o && (|in_i)) |=> state_o);
endmodule

// File: rtl/dr_word_receiver.sv
// Dual-rail four-phase word receiver: synchronises the rails, decodes
// each pair, merges validity through a C-element, captures the word on
// completion and drives a return-to-zero acknowledge.
// Assumes: the sender holds each phase until it sees the matching acknowledge edge.
module dr_word_receiver #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_t_i,
    input  logic [WIDTH-1:0] rail_f_i,
    output logic             done_o,
    output logic             ack_o,
    output logic [WIDTH-1:0] word_o,
    output logic             err_o
);
    logic [WIDTH-1:0] sync_t, sync_f;
    logic [WIDTH-1:0] bit_val, bit_valid, bit_bad;
    logic             done_q;
    logic             capture;

    dr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync_t (
        .clk(clk), .rst_n(rst_n), .d_i(rail_t_i), .q_o(sync_t));
    dr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync_f (
        .clk(clk), .rst_n(rst_n), .d_i(rail_f_i), .q_o(sync_f));

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pair
            dr_pair_decode u_dec (
                .rail_t   (sync_t[i]),
                .rail_f   (sync_f[i]),
                .value_o  (bit_val[i]),
                .valid_o  (bit_valid[i]),
                .illegal_o(bit_bad[i]));
        end
    endgenerate

    dr_celem #(.WIDTH(WIDTH)) u_celem (
        .clk(clk), .rst_n(rst_n), .in_i(bit_valid), .state_o(done_q));

    // Capture happens on the first clock that sees completion high with acknowledge still low.
    always_comb capture = done_q && !ack_o;

    // Acknowledge trails completion by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_o <= 1'b0;
        else        ack_o <= done_q;
    end

    // Load the decoded word once, when completion rises.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_o <= '0;
        else if (capture) word_o <= bit_val;
    end

    // Set the error flag on any illegal pair; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_o <= 1'b0;
        else if (|bit_bad) err_o <= 1'b1;
    end

    assign done_o = done_q;

    // R4: acknowledge follows completion one clock later.
    a_r4_ack_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ack_o);
    a_r4_ack_drops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> !ack_o);
    // R5: the word is steady while acknowledge stays high.
    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && done_o) |=> $stable(word_o));
    // R6: the error flag is sticky.
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: tb/tb_dr_word_receiver.sv
module tb_dr_word_receiver;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [W-1:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] rail_t = '0, rail_f = '0;
    logic done, ack, err;
    logic [W-1:0] word;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dr_word_receiver #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .rail_t_i(rail_t), .rail_f_i(rail_f),
        .done_o(done), .ack_o(ack), .word_o(word), .err_o(err));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Full four-phase transfer with edge-exact latency checks.
    task automatic transfer(input logic [W-1:0] v);
        @(negedge clk); rail_t = v; rail_f = ~v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 done after 3 edges", done, 1);
        chk("R4 ack low after 3 edges", ack, 0);
        @(negedge clk);
        chk("R4 ack after 4 edges", ack, 1);
        chk("R1 R8 decoded word", word, v);
        rail_t = '0; rail_f = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 done low after spacer", done, 0);
        chk("R4 ack still high", ack, 1);
        @(negedge clk);
        chk("R4 ack low", ack, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        chk("R7 ack", ack, 0); chk("R7 done", done, 0);
        chk("R7 err", err, 0); chk("R7 word", word, 0);
        rst_n = 1'b1;

        // R1 R8: table-driven transfers
        for (int k = 0; k < NVEC; k++) transfer(VEC[k]);

        // R2: half-valid word must not complete
        @(negedge clk); rail_t = 8'h03; rail_f = 8'h0C;
        repeat (8) @(negedge clk);
        chk("R2 partial done", done, 0); chk("R2 partial ack", ack, 0);
        rail_t = 8'h33; rail_f = 8'hCC;
        repeat (4) @(negedge clk);
        chk("R2 complete ack", ack, 1); chk("R1 word", word, 8'h33);

        // R3: half-returned word must keep completion
        rail_t = 8'h30; rail_f = 8'hC0;
        repeat (8) @(negedge clk);
        chk("R3 partial spacer done", done, 1); chk("R3 partial spacer ack", ack, 1);
        // R5: rails changed under acknowledge leave word untouched
        rail_t = 8'hCC; rail_f = 8'h33;
        repeat (6) @(negedge clk);
        chk("R5 word held", word, 8'h33);
        rail_t = '0; rail_f = '0;
        repeat (4) @(negedge clk);
        chk("R3 full spacer ack", ack, 0);

        // R6: illegal pair on bit 0
        rail_t = 8'h01; rail_f = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R6 err set", err, 1);
        rail_t = '0; rail_f = '0;
        repeat (4) @(negedge clk);
        transfer(8'h96);
        chk("R6 err sticky", err, 1);

        // R7: reset clears everything
        @(negedge clk); rail_t = 8'h0F; rail_f = 8'hF0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 err cleared", err, 0); chk("R7 ack cleared", ack, 0);
        chk("R7 word cleared", word, 0); chk("R7 done cleared", done, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule